// File: doc/BRIEF.md
# Dual Staging Buffer with Role Swap

This block holds write data in two on-chip staging buffers before that data goes to a flash programming engine. At any time one buffer is active. All loads, read-backs and commits address the active buffer. Software can exchange the roles of the two buffers, so that one buffer can be refilled while the other keeps its contents. A separate command decoder turns command bytes into one-cycle strobes. It then forwards the argument bytes that follow a command as beats on a shared argument bus.

Data reaches the active buffer in one of two ways. A single load writes one byte at an explicit address. A sequential load takes a 16-bit byte count, low byte first and then high byte, and then stores the data beats that follow at addresses counting up from zero. A commit also takes a 16-bit count, low byte then high byte. On the high-count beat it captures a target flash address. It then streams that many bytes, starting at buffer address zero, to a write engine over a valid/ready port, and pulses a completion flag at the end. A swap requested while a commit is streaming is held back until that commit has finished.

Top module: `stage_buf`

## Requirements
- R1: After reset, act_o, rd_vld_o, err_o, out_valid_o and done_o are all 0, and buffer 0 is active.
- R2: A ld_one_i strobe writes arg_i at address addr_i of the active buffer.
- R3: After seq_start_i, the first argument beat is the count low byte and the second is the count high byte. The next count beats on arg_i are written to active-buffer addresses 0, 1, 2 and so on. A beat that arrives after the count is used up writes nothing.
- R4: If a sequential load count exceeds 256, err_o goes to 1 on the high-count beat and the load stops after address 255, with no wrap to address 0. err_o returns to 0 when the next sequential load or commit is accepted.
- R5: When rd_i is high in a cycle, then in the next cycle rd_vld_o is 1 and rd_data_o holds the byte at addr_i of the active buffer.
- R6: When no commit is streaming, swap_i toggles act_o on the next clock edge. The two buffers keep separate contents.
- R7: After commit_i, the first argument beat is the count low byte. The second is the count high byte, and on that beat fl_addr_i is captured as the base address. Beat k of the stream then carries byte k of the buffer that was active at that point, at address base+k.
- R8: While out_valid_o is 1 and out_ready_i is 0, out_valid_o, out_data_o and out_addr_o do not change, provided the buffer being streamed is not written.
- R9: done_o is a one-cycle pulse, raised in the cycle after the last beat is accepted. A commit count of 0 raises done_o in the cycle after the high-count beat, with no beat sent.
- R10: A swap_i during streaming leaves act_o unchanged until done_o has pulsed. act_o then toggles on the edge where done_o falls.
- R11: A commit count above 256 sets err_o and is clamped to 256 beats.
- R12: commit_i is ignored while a stream is active. seq_start_i and commit_i are ignored while a previous command is still collecting arguments. Argument beats with no command pending have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_one_i | input | 1 | Single-location load strobe (address addr_i, data arg_i) |
| seq_start_i | input | 1 | Starts a counted sequential load |
| rd_i | input | 1 | Read-back strobe (address addr_i) |
| swap_i | input | 1 | Exchange the roles of the two buffers |
| commit_i | input | 1 | Starts a commit of the active buffer |
| arg_vld_i | input | 1 | Argument beat valid |
| arg_i | input | DW | Argument byte (count byte or data) |
| addr_i | input | AW | Buffer address for single load and read-back |
| fl_addr_i | input | FAW | Flash base address, captured on the commit high-count beat |
| act_o | output | 1 | Index of the active buffer |
| rd_vld_o | output | 1 | Read-back data valid |
| rd_data_o | output | DW | Read-back data |
| err_o | output | 1 | Oversized count flag |
| out_valid_o | output | 1 | Commit beat valid |
| out_ready_i | input | 1 | Write engine accepts the beat |
| out_data_o | output | DW | Commit beat data |
| out_addr_o | output | FAW | Commit beat flash address |
| done_o | output | 1 | Commit complete pulse |

## Verification
The bound checker watches the stream handshake on every cycle. It checks that a stalled beat is held (R8), that accepted beats advance the address by one (R7), that done_o lasts one cycle and never overlaps a valid beat (R9), and that act_o stays fixed while streaming (R10). It also checks the read-back latency (R5). Where data lands in the buffers, the stop at address 255 on an oversized load, the clamped commit length, the zero-length commit, and the ignored commands and stray argument beats are visible only through the bench scenarios. There a behavioural model predicts every output in every cycle.

// File: rtl/stage_buf_pkg.sv
package stage_buf_pkg;
  typedef enum logic [2:0] {
    ARG_IDLE,
    ARG_SEQ_LO,
    ARG_SEQ_HI,
    ARG_SEQ_DAT,
    ARG_CMT_LO,
    ARG_CMT_HI
  } arg_st_e;
endpackage

// File: rtl/stage_buf_mem.sv
module stage_buf_mem #(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic          wsel_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          ra_sel_i,
  input  logic [AW-1:0] ra_addr_i,
  output logic [DW-1:0] ra_data_o,
  input  logic          rb_sel_i,
  input  logic [AW-1:0] rb_addr_i,
  output logic [DW-1:0] rb_data_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] ra_bank [2];
  logic [DW-1:0] rb_bank [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [DW-1:0] mem [DEPTH];
    always_ff @(posedge clk_i) begin
      if (we_i && (wsel_i == 1'(b))) mem[waddr_i] <= wdata_i;
    end
    assign ra_bank[b] = mem[ra_addr_i];
    assign rb_bank[b] = mem[rb_addr_i];
  end

  assign ra_data_o = ra_bank[ra_sel_i];
  assign rb_data_o = rb_bank[rb_sel_i];
endmodule

// File: rtl/stage_buf_ctl.sv
module stage_buf_ctl
  import stage_buf_pkg::*;
#(
  parameter int DW  = 8,
  parameter int AW  = 8,
  parameter int FAW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              seq_start_i,
  input  logic              commit_i,
  input  logic              arg_vld_i,
  input  logic [DW-1:0]     arg_i,
  input  logic [FAW-1:0]    fl_addr_i,
  input  logic              busy_i,
  output logic              seq_we_o,
  output logic [AW-1:0]     seq_addr_o,
  output logic              cmt_start_o,
  output logic [AW:0]       cmt_cnt_o,
  output logic [FAW-1:0]    cmt_base_o,
  output logic              err_o
);
  localparam int DEPTH = 1 << AW;
  localparam int CNT_W = AW + 1;
  localparam int FULL_W = 2 * DW;

  arg_st_e            st_q;
  logic [DW-1:0]      lo_q;
  logic [CNT_W-1:0]   rem_q;
  logic [AW-1:0]      ptr_q;
  logic               err_q;
  logic [FULL_W-1:0]  full;
  logic               big;
  logic [CNT_W-1:0]   clamp;

  assign full  = {arg_i, lo_q};
  assign big   = full > FULL_W'(DEPTH);
  assign clamp = big ? CNT_W'(DEPTH) : CNT_W'(full);

  assign seq_we_o    = (st_q == ARG_SEQ_DAT) && arg_vld_i;
  assign seq_addr_o  = ptr_q;
  assign cmt_start_o = (st_q == ARG_CMT_HI) && arg_vld_i;
  assign cmt_cnt_o   = clamp;
  assign cmt_base_o  = fl_addr_i;
  assign err_o       = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ARG_IDLE;
      lo_q  <= '0;
      rem_q <= '0;
      ptr_q <= '0;
      err_q <= 1'b0;
    end else begin
      unique case (st_q)
        ARG_IDLE: begin
          if (seq_start_i) begin
            st_q  <= ARG_SEQ_LO;
            err_q <= 1'b0;
          end else if (commit_i && !busy_i) begin
            st_q  <= ARG_CMT_LO;
            err_q <= 1'b0;
          end
        end
        ARG_SEQ_LO, ARG_CMT_LO: begin
          if (arg_vld_i) begin
            lo_q <= arg_i;
            st_q <= (st_q == ARG_SEQ_LO) ? ARG_SEQ_HI : ARG_CMT_HI;
          end
        end
        ARG_SEQ_HI: begin
          if (arg_vld_i) begin
            rem_q <= clamp;
            ptr_q <= '0;
            if (big) err_q <= 1'b1;
            st_q <= (full == '0) ? ARG_IDLE : ARG_SEQ_DAT;
          end
        end
        ARG_SEQ_DAT: begin
          if (arg_vld_i) begin
            ptr_q <= ptr_q + AW'(1);
            rem_q <= rem_q - CNT_W'(1);
            if (rem_q == CNT_W'(1)) st_q <= ARG_IDLE;
          end
        end
        ARG_CMT_HI: begin
          if (arg_vld_i) begin
            if (big) err_q <= 1'b1;
            st_q <= ARG_IDLE;
          end
        end
        default: st_q <= ARG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/stage_buf_stream.sv
module stage_buf_stream #(
  parameter int AW  = 8,
  parameter int FAW = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [AW:0]    cnt_i,
  input  logic [FAW-1:0] base_i,
  input  logic           rdy_i,
  output logic           valid_o,
  output logic [AW-1:0]  idx_o,
  output logic [FAW-1:0] addr_o,
  output logic           done_o
);
  localparam int CNT_W = AW + 1;

  logic             busy_q;
  logic             done_q;
  logic [CNT_W-1:0] rem_q;
  logic [AW-1:0]    idx_q;
  logic [FAW-1:0]   base_q;

  assign valid_o = busy_q;
  assign idx_o   = idx_q;
  assign addr_o  = base_q + FAW'(idx_q);
  assign done_o  = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      rem_q  <= '0;
      idx_q  <= '0;
      base_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        if (rdy_i) begin
          idx_q <= idx_q + AW'(1);
          rem_q <= rem_q - CNT_W'(1);
          if (rem_q == CNT_W'(1)) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end else if (start_i) begin
        if (cnt_i == '0) begin
          done_q <= 1'b1;
        end else begin
          busy_q <= 1'b1;
          rem_q  <= cnt_i;
          idx_q  <= '0;
          base_q <= base_i;
        end
      end
    end
  end
endmodule

// File: rtl/stage_buf.sv
module stage_buf #(
  parameter int DW  = 8,
  parameter int AW  = 8,
  parameter int FAW = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           ld_one_i,
  input  logic           seq_start_i,
  input  logic           rd_i,
  input  logic           swap_i,
  input  logic           commit_i,
  input  logic           arg_vld_i,
  input  logic [DW-1:0]  arg_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [FAW-1:0] fl_addr_i,
  output logic           act_o,
  output logic           rd_vld_o,
  output logic [DW-1:0]  rd_data_o,
  output logic           err_o,
  output logic           out_valid_o,
  input  logic           out_ready_i,
  output logic [DW-1:0]  out_data_o,
  output logic [FAW-1:0] out_addr_o,
  output logic           done_o
);
  logic           act_q, pend_q, cbuf_q;
  logic           rd_vld_q;
  logic [DW-1:0]  rd_data_q;
  logic           seq_we;
  logic [AW-1:0]  seq_addr;
  logic           cmt_start;
  logic [AW:0]    cmt_cnt;
  logic [FAW-1:0] cmt_base;
  logic           busy;
  logic [AW-1:0]  idx;
  logic           we;
  logic [AW-1:0]  waddr;
  logic [DW-1:0]  rdata;

  // sequential data wins over a colliding single load
  assign we    = seq_we | ld_one_i;
  assign waddr = seq_we ? seq_addr : addr_i;

  stage_buf_ctl #(.DW(DW), .AW(AW), .FAW(FAW)) u_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .seq_start_i (seq_start_i),
    .commit_i    (commit_i),
    .arg_vld_i   (arg_vld_i),
    .arg_i       (arg_i),
    .fl_addr_i   (fl_addr_i),
    .busy_i      (busy),
    .seq_we_o    (seq_we),
    .seq_addr_o  (seq_addr),
    .cmt_start_o (cmt_start),
    .cmt_cnt_o   (cmt_cnt),
    .cmt_base_o  (cmt_base),
    .err_o       (err_o)
  );

  stage_buf_stream #(.AW(AW), .FAW(FAW)) u_stream (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (cmt_start),
    .cnt_i   (cmt_cnt),
    .base_i  (cmt_base),
    .rdy_i   (out_ready_i),
    .valid_o (busy),
    .idx_o   (idx),
    .addr_o  (out_addr_o),
    .done_o  (done_o)
  );

  stage_buf_mem #(.DW(DW), .AW(AW)) u_mem (
    .clk_i     (clk_i),
    .we_i      (we),
    .wsel_i    (act_q),
    .waddr_i   (waddr),
    .wdata_i   (arg_i),
    .ra_sel_i  (act_q),
    .ra_addr_i (addr_i),
    .ra_data_o (rdata),
    .rb_sel_i  (cbuf_q),
    .rb_addr_i (idx),
    .rb_data_o (out_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q     <= 1'b0;
      pend_q    <= 1'b0;
      cbuf_q    <= 1'b0;
      rd_vld_q  <= 1'b0;
      rd_data_q <= '0;
    end else begin
      rd_vld_q <= rd_i;
      if (rd_i) rd_data_q <= rdata;
      if (cmt_start) cbuf_q <= act_q;
      if ((swap_i || pend_q) && !busy) begin
        act_q  <= ~act_q;
        pend_q <= 1'b0;
      end else if (swap_i) begin
        pend_q <= 1'b1;
      end
    end
  end

  assign act_o       = act_q;
  assign rd_vld_o    = rd_vld_q;
  assign rd_data_o   = rd_data_q;
  assign out_valid_o = busy;
endmodule

// File: rtl/stage_buf_chk.sv
module stage_buf_chk #(
  parameter int DW  = 8,
  parameter int FAW = 16
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           rd_i,
  input logic           out_ready_i,
  input logic           act_o,
  input logic           rd_vld_o,
  input logic           out_valid_o,
  input logic [DW-1:0]  out_data_o,
  input logic [FAW-1:0] out_addr_o,
  input logic           done_o
);
  AST_HOLD_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o) && $stable(out_addr_o)); // R8
  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ready_i |=> !out_valid_o || (out_addr_o == $past(out_addr_o) + FAW'(1))); // R7
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !out_valid_o); // R9
  AST_SWAP_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> $stable(act_o)); // R10
  AST_RD_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> rd_vld_o); // R5
endmodule

bind stage_buf stage_buf_chk #(.DW(DW), .FAW(FAW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rd_i        (rd_i),
  .out_ready_i (out_ready_i),
  .act_o       (act_o),
  .rd_vld_o    (rd_vld_o),
  .out_valid_o (out_valid_o),
  .out_data_o  (out_data_o),
  .out_addr_o  (out_addr_o),
  .done_o      (done_o)
);

// File: tb/sim_stage_buf.sv
`timescale 1ns/1ps
module sim_stage_buf;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_one = 0, seq_start = 0, rd = 0, swap = 0, commit = 0, arg_vld = 0, rdy = 1;
  logic [7:0] arg = 0, addr = 0;
  logic [15:0] fl_addr = 0;
  logic act, rd_vld, err, out_valid, done;
  logic [7:0] rd_data, out_data;
  logic [15:0] out_addr;

  always #5 clk = ~clk;

  stage_buf u0 (
    .clk_i(clk), .rst_ni(rst_n), .ld_one_i(ld_one), .seq_start_i(seq_start), .rd_i(rd),
    .swap_i(swap), .commit_i(commit), .arg_vld_i(arg_vld), .arg_i(arg), .addr_i(addr),
    .fl_addr_i(fl_addr), .act_o(act), .rd_vld_o(rd_vld), .rd_data_o(rd_data), .err_o(err),
    .out_valid_o(out_valid), .out_ready_i(rdy), .out_data_o(out_data), .out_addr_o(out_addr),
    .done_o(done)
  );

  int checks = 0, fails = 0, cyc = 0, rmode = 0;
  int beats = 0, dones = 0;
  bit ended = 0, held = 0;
  int held_data = 0, held_addr = 0;

  // reference model state
  int m_mem [2][256];
  int m_act = 0, m_pend = 0, m_st = 0, m_lo = 0, m_rem = 0, m_ptr = 0, m_err = 0;
  int m_busy = 0, m_idx = 0, m_crem = 0, m_base = 0, m_cbuf = 0, m_done = 0, m_rdv = 0, m_rdd = 0;

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic model_step();
    int oa = m_act;
    int ob = m_busy;
    int os = m_st;
    int full;
    m_rdv = rd;
    if (rd) m_rdd = m_mem[oa][addr];
    m_done = 0;
    if (ob != 0 && rdy) begin
      m_idx++; m_crem--;
      if (m_crem == 0) begin m_busy = 0; m_done = 1; end
    end
    if ((swap || m_pend != 0) && ob == 0) begin m_act = 1 - oa; m_pend = 0; end
    else if (swap) m_pend = 1;
    full = arg * 256 + m_lo;
    case (os)
      0: if (seq_start) begin m_st = 1; m_err = 0; end
         else if (commit && ob == 0) begin m_st = 4; m_err = 0; end
      1: if (arg_vld) begin m_lo = arg; m_st = 2; end
      4: if (arg_vld) begin m_lo = arg; m_st = 5; end
      2: if (arg_vld) begin
           if (full > 256) begin m_err = 1; m_rem = 256; end else m_rem = full;
           m_ptr = 0; m_st = (full == 0) ? 0 : 3;
         end
      3: if (arg_vld) begin
           m_mem[oa][m_ptr] = arg; m_ptr++; m_rem--;
           if (m_rem == 0) m_st = 0;
         end
      5: if (arg_vld) begin
           if (full > 256) begin m_err = 1; full = 256; end
           if (full == 0) m_done = 1;
           else begin m_busy = 1; m_idx = 0; m_crem = full; m_base = fl_addr; m_cbuf = oa; end
           m_st = 0;
         end
      default: ;
    endcase
    if (ld_one && !(os == 3 && arg_vld)) m_mem[oa][addr] = arg;
  endtask

  always @(posedge clk) if (rst_n) model_step();

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !ended) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    if (held) begin
      chk("R8 stalled data", out_data, held_data);
      chk("R8 stalled addr", out_addr, held_addr);
      held = 0;
    end
    chk("R6 act", act, m_act);
    chk("R5 rd_vld", rd_vld, m_rdv);
    if (m_rdv != 0) chk("R5 rd_data", rd_data, m_rdd);
    chk("R4 err", err, m_err);
    chk("R7 valid", out_valid, m_busy);
    if (m_busy != 0) begin
      chk("R7 data", out_data, m_mem[m_cbuf][m_idx]);
      chk("R7 addr", out_addr, (m_base + m_idx) & 16'hFFFF);
    end
    chk("R9 done", done, m_done);
    if (done) dones++;
    ld_one = 0; seq_start = 0; rd = 0; swap = 0; commit = 0; arg_vld = 0;
    case (rmode)
      1: rdy = cyc[0];
      2: rdy = (cyc % 3) != 0;
      default: rdy = 1;
    endcase
    if (out_valid && rdy) beats++;
    if (out_valid && !rdy) begin held = 1; held_data = out_data; held_addr = out_addr; end
  endtask

  task automatic put_arg(int v);
    arg_vld = 1; arg = 8'(v); tick();
  endtask

  task automatic rd_check(int a, int exp, string tag);
    rd = 1; addr = 8'(a); tick();
    chk(tag, rd_data, exp);
  endtask

  task automatic wait_done();
    int d0 = dones;
    for (int i = 0; i < 2000 && dones == d0; i++) tick();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 act", act, 0); chk("R1 rd_vld", rd_vld, 0); chk("R1 err", err, 0);
    chk("R1 valid", out_valid, 0); chk("R1 done", done, 0);
    rst_n = 1;
    tick();

    // R2 single load
    ld_one = 1; addr = 10; arg = 8'hA5; tick();
    rd_check(10, 8'hA5, "R2 single load");

    // R6 swap, separate contents
    swap = 1; tick();
    chk("R6 toggled", act, 1);
    ld_one = 1; addr = 10; arg = 8'h3C; tick();
    rd_check(10, 8'h3C, "R6 buffer1");
    swap = 1; tick();
    rd_check(10, 8'hA5, "R6 buffer0 kept");

    // R3 sequential load, extra beat ignored
    ld_one = 1; addr = 5; arg = 8'h5A; tick();
    seq_start = 1; tick();
    put_arg(5); put_arg(0);
    for (int i = 0; i < 5; i++) put_arg((i + 1) * 8'h11);
    put_arg(8'h77);
    rd_check(0, 8'h11, "R3 first");
    rd_check(4, 8'h55, "R3 last");
    rd_check(5, 8'h5A, "R3 extra beat ignored");

    // R4 oversized load stops at 255
    seq_start = 1; tick();
    put_arg(5); put_arg(1);
    chk("R4 err set", err, 1);
    for (int i = 0; i < 261; i++) put_arg(i < 256 ? ((i * 7 + 3) & 255) : 8'hEE);
    rd_check(0, 3, "R4 no wrap");
    rd_check(255, 8'hFC, "R4 last address");

    // R7/R8 commit of 8 with stalls
    rmode = 1; beats = 0;
    commit = 1; tick();
    chk("R4 err cleared", err, 0);
    put_arg(8); fl_addr = 16'h1000; put_arg(0);
    chk("R7 first addr", out_addr, 16'h1000);
    chk("R7 first data", out_data, 3);
    wait_done();
    tick();
    chk("R7 beat count", beats, 8);

    // R11 clamp to 256
    rmode = 0; beats = 0;
    commit = 1; tick();
    put_arg(8'h2C); fl_addr = 16'hFF80; put_arg(1);
    chk("R11 err", err, 1);
    wait_done();
    tick();
    chk("R11 beat count", beats, 256);

    // R10/R12 deferred swap, ignored commit and stray beats
    rmode = 2; beats = 0;
    commit = 1; tick();
    put_arg(20); fl_addr = 16'h0200; put_arg(0);
    repeat (3) tick();
    swap = 1; tick();
    commit = 1; tick();
    put_arg(3); put_arg(0);
    chk("R10 act held", act, 0);
    wait_done();
    chk("R10 act before toggle", act, 0);
    tick();
    chk("R10 act after done", act, 1);
    chk("R12 beat count", beats, 20);
    repeat (3) tick();
    chk("R12 no extra stream", out_valid, 0);

    // R9 zero-length commit
    swap = 1; tick();
    commit = 1; tick();
    put_arg(0); put_arg(0);
    chk("R9 zero done", done, 1);
    chk("R9 zero no beat", out_valid, 0);
    tick();
    chk("R9 pulse ends", done, 0);

    summary();
  end
endmodule